// File: doc/BRIEF.md
# Clear-on-Read Interrupt Flag Register

This block keeps three sticky event flags for a timekeeping peripheral: one for the periodic tick, one for the alarm match and one for the end of a time update. A one-cycle pulse on an event input sets the matching flag. The flag is set whether or not that event's enable bit is on.

The flags are presented as one 8-bit byte. Bit 7 of that byte is a summary bit, and an interrupt request line follows it. Both count only those flags whose enable bit is 1.

A read strobe marks the cycle in which software reads the byte. The byte seen in that cycle is the state before the read. From the next cycle on, every flag is clear, except a flag whose event arrives in the same cycle as the read.

Top module: `irqf_flag_reg`

## Requirements
- R1: After reset, the flag byte reads 8'h00 and irq is 0.
- R2: A pulse on evt_periodic sets bit 6, a pulse on evt_alarm sets bit 5 and a pulse on evt_update sets bit 4. Each bit is visible in the cycle after the pulse, whatever the state of the enables.
- R3: Bits 3 to 0 of the flag byte always read 0.
- R4: Bit 7 of the flag byte is 1 exactly when at least one flag among bits 6..4 is set and its enable is 1. The enables are en_periodic for bit 6, en_alarm for bit 5 and en_update for bit 4. A set flag that is not enabled does not drive bit 7.
- R5: irq equals bit 7 of the flag byte. It is a level signal that stays high with no further events, until a read or a drop of the enable.
- R6: In the cycle where rd_stb is 1, the byte shows the state before the read. From the next cycle on, the flags are clear and irq is 0, provided no event arrived with the read.
- R7: An event pulse in the same cycle as rd_stb leaves its flag set after the read.
- R8: With no event pulse and no read, every flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_periodic | input | 1 | Periodic tick event pulse |
| evt_alarm | input | 1 | Alarm match event pulse |
| evt_update | input | 1 | Update-ended event pulse |
| en_periodic | input | 1 | Enable of the periodic flag into the summary |
| en_alarm | input | 1 | Enable of the alarm flag into the summary |
| en_update | input | 1 | Enable of the update flag into the summary |
| rd_stb | input | 1 | One cycle per read of the flag byte |
| flag_byte | output | 8 | Summary bit 7, flags 6..4, zeros 3..0 |
| irq | output | 1 | Interrupt request level |

## Verification
The assertions take the event inputs and the read strobe to be synchronous to clk and free of X after reset. They also assume that an enable does not change in a cycle where the interrupt hold is judged, and the hold check forgives any enable that has just fallen. The stimulus changes every input only on the falling clock edge, and it never drops an enable during the hold checks. Reads are issued both with and without a coinciding event, which covers the case where a new event and a clearing read land together.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
   // number of event sources and their index inside the event vector
   localparam int unsigned EVT_N      = 3;
   localparam int unsigned IDX_UPDATE = 0;
   localparam int unsigned IDX_ALARM  = 1;
   localparam int unsigned IDX_PERIOD = 2;

   typedef logic [EVT_N-1:0] evt_vec_t;

   function automatic evt_vec_t pack_evt(input logic periodic,
                                         input logic alarm,
                                         input logic update);
      evt_vec_t v;
      v             = '0;
      v[IDX_PERIOD] = periodic;
      v[IDX_ALARM]  = alarm;
      v[IDX_UPDATE] = update;
      return v;
   endfunction
endpackage

// File: rtl/irqf_cell.sv
module irqf_cell #(
   parameter bit EVENT_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic rd,
   output logic flag_q
);
   logic flag_d;

   generate
      if (EVENT_WINS) begin : g_evt_wins
         always_comb flag_d = rd ? evt : (flag_q | evt);
      end else begin : g_rd_wins
         always_comb flag_d = rd ? 1'b0 : (flag_q | evt);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      evt && !rd |=> flag_q);

   assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd && !evt |=> !flag_q);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd && !evt |=> flag_q == $past(flag_q));

   generate
      if (EVENT_WINS) begin : g_keep_chk
         assert_read_keeps_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
            rd && evt |=> flag_q);
      end
   endgenerate
endmodule

// File: rtl/irqf_summary.sv
module irqf_summary #(
   parameter int unsigned N = 3
) (
   input  logic [N-1:0] flags,
   input  logic [N-1:0] en,
   output logic         any
);
   logic [N:0] chain;

   assign chain[0] = 1'b0;
   generate
      for (genvar i = 0; i < N; i++) begin : g_or
         assign chain[i+1] = chain[i] | (flags[i] & en[i]);
      end
   endgenerate
   assign any = chain[N];
endmodule

// File: rtl/irqf_flag_reg.sv
module irqf_flag_reg
   import irqf_pkg::*;
#(
   parameter int unsigned FLAG_W     = 8,
   parameter int unsigned EVT_LSB    = 4,
   parameter bit          EVENT_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_periodic,
   input  logic              evt_alarm,
   input  logic              evt_update,
   input  logic              en_periodic,
   input  logic              en_alarm,
   input  logic              en_update,
   input  logic              rd_stb,
   output logic [FLAG_W-1:0] flag_byte,
   output logic              irq
);
   localparam int unsigned SUM_POS = FLAG_W - 1;
   localparam int unsigned EVT_MSB = EVT_LSB + EVT_N - 1;

   generate
      if (EVT_MSB >= SUM_POS) begin : g_bad_layout
         $error("event field overlaps the summary bit");
      end
   endgenerate

   evt_vec_t evt_vec, en_vec, flags;
   logic     any_en;

   assign evt_vec = pack_evt(evt_periodic, evt_alarm, evt_update);
   assign en_vec  = pack_evt(en_periodic, en_alarm, en_update);

   generate
      for (genvar i = 0; i < EVT_N; i++) begin : g_cell
         irqf_cell #(.EVENT_WINS(EVENT_WINS)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt_vec[i]),
            .rd     (rd_stb),
            .flag_q (flags[i])
         );
      end
   endgenerate

   irqf_summary #(.N(EVT_N)) u_sum (
      .flags (flags),
      .en    (en_vec),
      .any   (any_en)
   );

   generate
      for (genvar b = 0; b < FLAG_W; b++) begin : g_byte
         if (b == SUM_POS) begin : g_sum
            assign flag_byte[b] = any_en;
         end else if (b >= EVT_LSB && b <= EVT_MSB) begin : g_flag
            assign flag_byte[b] = flags[b-EVT_LSB];
         end else begin : g_zero
            assign flag_byte[b] = 1'b0;
         end
      end
   endgenerate

   assign irq = any_en;

   assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !rd_stb |=> irq || (($past(en_vec) & ~en_vec) != '0));

   assert_read_drops_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb && evt_vec == '0 |=> !irq && flag_byte == '0);

   assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      en_vec == '0 |-> !flag_byte[SUM_POS]);
endmodule

// File: tb/irqf_flag_reg_tb.sv
module irqf_flag_reg_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ep = 0, ea = 0, eu = 0;
   logic       np = 0, na = 0, nu = 0;
   logic       rd = 0;
   logic [7:0] fb;
   logic       irq;
   int         n_cmp = 0, n_bad = 0;

   always #5 clk = ~clk;

   irqf_flag_reg u_dut (
      .clk(clk), .rst_n(rst_n),
      .evt_periodic(ep), .evt_alarm(ea), .evt_update(eu),
      .en_periodic(np), .en_alarm(na), .en_update(nu),
      .rd_stb(rd), .flag_byte(fb), .irq(irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic pulse(input logic p, input logic a, input logic u);
      @(negedge clk); ep = p; ea = a; eu = u;
      @(negedge clk); ep = 0; ea = 0; eu = 0;
   endtask

   task automatic do_read(input logic [7:0] exp_during);
      @(negedge clk); rd = 1;
      #1 chk("R6 value during read", fb, exp_during);
      @(negedge clk); rd = 0;
   endtask

   task automatic t_reset;
      chk("R1 byte", fb, 8'h00);
      chk("R1 irq", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_set_masked;
      pulse(1, 0, 0);
      chk("R2 periodic masked", fb, 8'h40);
      chk("R4 no summary when masked", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_late_enable;
      @(negedge clk); np = 1; #1;
      chk("R4 late enable", fb, 8'hC0);
      chk("R5 irq follows", {7'd0, irq}, 8'h01);
      repeat (5) @(negedge clk);
      chk("R5 level held", {7'd0, irq}, 8'h01);
      chk("R8 flags held", fb, 8'hC0);
   endtask

   task automatic t_read_clear;
      do_read(8'hC0);
      chk("R6 cleared", fb, 8'h00);
      chk("R6 irq low", {7'd0, irq}, 8'h00);
      do_read(8'h00);
      chk("R6 empty read", fb, 8'h00);
   endtask

   task automatic t_each_source;
      @(negedge clk); np = 0; na = 1; nu = 0;
      pulse(0, 1, 0);
      chk("R2 alarm", fb, 8'hA0);
      do_read(8'hA0);
      @(negedge clk); na = 0; nu = 1;
      pulse(0, 0, 1);
      chk("R2 update", fb, 8'h90);
      chk("R3 low nibble", {4'd0, fb[3:0]}, 8'h00);
      pulse(1, 1, 0);
      chk("R2 all three", fb, 8'hF0);
      do_read(8'hF0);
   endtask

   task automatic t_mask_mismatch;
      @(negedge clk); na = 0; nu = 1; np = 0;
      pulse(0, 1, 0);
      chk("R4 alarm flag, update enabled only", fb, 8'h20);
      chk("R4 irq low", {7'd0, irq}, 8'h00);
      do_read(8'h20);
   endtask

   task automatic t_coincide;
      pulse(0, 0, 1);
      chk("R7 setup", fb, 8'h90);
      @(negedge clk); rd = 1; ea = 1;
      @(negedge clk); rd = 0; ea = 0;
      chk("R7 event survives read", fb, 8'h20);
      chk("R7 irq low", {7'd0, irq}, 8'h00);
      @(negedge clk); na = 1; #1;
      chk("R4 kept flag enabled", fb, 8'hA0);
      do_read(8'hA0);
      chk("R6 final clear", fb, 8'h00);
   endtask

   initial begin
      #(200000 * 10);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1;
      @(negedge clk);
      t_reset;
      t_set_masked;
      t_late_enable;
      t_read_clear;
      t_each_source;
      t_mask_mismatch;
      t_coincide;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule